// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins an A bus and a B bus through two independently controlled byte lanes. In each lane, one path carries data from A toward B and another carries it from B toward A. Each path has its own edge-triggered storage register with its own clock and synchronous reset, and its own select input. The select input decides whether the opposite bus is driven with the live input or with the stored word. Each path also has an enable, and the two enables use opposite polarity. The two lanes can be run separately as two byte-wide transceivers, or together as one 16-bit transceiver.

The pins are not true tri-state pins. Each bus is modelled as an input vector (the resolved level on the wire), an output vector and an output-enable flag for each lane. Each lane also has a flag that marks when an outside agent is driving its A or B side.

In real-time mode, both paths of a lane can be enabled at the same time. When that happens, each bus is driven from the other. The lane then behaves like a bus keeper, and a per-lane hold register, clocked by a core clock, supplies the kept level. That level comes from whichever side is driven from outside. If neither side is driven from outside, the lane keeps the last level seen on its A side.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: Asserting a path's reset with a rising edge of that path's storage clock clears that storage register to zero. Zero is visible at the opposite bus when that path is enabled and its select is high.
- R2: For each lane, the B-side output enable equals the A-to-B enable input, which is active high. The A-side output enable equals the inverse of the B-to-A enable input, which is active low.
- R3: A path whose enable is inactive drives an all-zero output word.
- R4: An enabled path whose select is low drives the current input word of its source bus, unless the lane is in loop mode (R8).
- R5: An enabled path whose select is high drives its storage register's contents.
- R6: On a rising edge of its storage clock, the A-side register captures the A input word, and the B-side register captures the B input word. This capture happens at any level of select and enable.
- R7: Storage registers change only at their own clock edges. Changes to select or enable between edges leave them unchanged.
- R8: Loop mode holds in a lane when both paths are enabled and both selects are low. In loop mode, both outputs carry the same word. That word is the A input when the external-A flag is set, otherwise the B input when the external-B flag is set, otherwise the hold register.
- R9: On each rising core clock edge, the hold register loads the A-side level. That level is the A output when the A-side output enable is set, and otherwise the A input. So when a lane enters loop mode with no outside driver, it keeps the last A-side level. The core reset clears the hold register.
- R10: The lanes are independent. Controls and clocks of one lane do not change the storage or outputs of the other lane. Lane k uses bits [8k+7:8k] of each bus word.
- R11: The select path is purely combinational. When the stored word equals the live word, toggling select leaves the driven word unchanged, with no intermediate value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock for the hold registers |
| rst | input | 1 | Synchronous active-high reset of the hold registers |
| st_clk_ab | input | LANES | Per-lane capture clock of the A-side register |
| st_rst_ab | input | LANES | Per-lane synchronous reset of the A-side register |
| st_clk_ba | input | LANES | Per-lane capture clock of the B-side register |
| st_rst_ba | input | LANES | Per-lane synchronous reset of the B-side register |
| en_ab | input | LANES | A-to-B enable, active high |
| en_ba_n | input | LANES | B-to-A enable, active low |
| src_ab | input | LANES | A-to-B source select: 0 live, 1 stored |
| src_ba | input | LANES | B-to-A source select: 0 live, 1 stored |
| a_in | input | LANES*LANE_W | Resolved level on the A bus |
| a_ext | input | LANES | An outside agent drives the A side of the lane |
| a_out | output | LANES*LANE_W | Word driven onto the A bus |
| a_oe | output | LANES | A-side output enable per lane |
| b_in | input | LANES*LANE_W | Resolved level on the B bus |
| b_ext | input | LANES | An outside agent drives the B side of the lane |
| b_out | output | LANES*LANE_W | Word driven onto the B bus |
| b_oe | output | LANES | B-side output enable per lane |

## Verification
The bench builds the block with its defaults: two lanes of eight bits. That choice brings two things within reach. First, lane-crossing faults can be seen: a clock, select or enable of one lane reaching the other. Second, the combined 16-bit word can be checked against a single 16-bit expectation. Random stimulus runs through every select and enable mix and every external-driver flag in both lanes, and it biases steps toward loop mode. Directed steps reach capture while disabled, keeper entry with no driver, and select toggling over equal words.

// File: rtl/bxr_pkg.sv
package bxr_pkg;

    // Source a path is driving onto its output bus.
    typedef enum logic [1:0] {
        PATH_OFF    = 2'd0,
        PATH_LIVE   = 2'd1,
        PATH_STORED = 2'd2,
        PATH_LOOP   = 2'd3
    } path_e;

endpackage

// File: rtl/bxr_store.sv
module bxr_store #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [W-1:0] word;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst_i) begin
            st_d.word = '0;
        end else begin
            st_d.word = d_i;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign q_o = st_q.word;

    AST_STORE_CLEAR: assert property (@(posedge clk_i)
        rst_i |=> (q_o == '0));                                  // R1

    AST_STORE_CAPTURE: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (q_o == $past(d_i)));                           // R6

endmodule

// File: rtl/bxr_path_mux.sv
module bxr_path_mux
    import bxr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         en_i,
    input  logic         sel_i,
    input  logic         loop_i,
    input  logic [W-1:0] live_i,
    input  logic [W-1:0] stored_i,
    input  logic [W-1:0] loop_val_i,
    output logic [W-1:0] out_o,
    output logic         oe_o
);

    path_e path;

    always_comb begin
        if (!en_i) begin
            path = PATH_OFF;
        end else if (loop_i) begin
            path = PATH_LOOP;
        end else if (sel_i) begin
            path = PATH_STORED;
        end else begin
            path = PATH_LIVE;
        end
    end

    always_comb begin
        unique case (path)
            PATH_OFF:    out_o = '0;
            PATH_LIVE:   out_o = live_i;
            PATH_STORED: out_o = stored_i;
            PATH_LOOP:   out_o = loop_val_i;
            default:     out_o = '0;
        endcase
    end

    assign oe_o = en_i;

endmodule

// File: rtl/bxr_lane.sv
module bxr_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         st_clk_ab,
    input  logic         st_rst_ab,
    input  logic         st_clk_ba,
    input  logic         st_rst_ba,
    input  logic         en_ab,
    input  logic         en_ba_n,
    input  logic         src_ab,
    input  logic         src_ba,
    input  logic [W-1:0] a_in,
    input  logic         a_ext,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    input  logic         b_ext,
    output logic [W-1:0] b_out,
    output logic         b_oe
);

    typedef struct packed {
        logic [W-1:0] keep;
    } keeper_t;

    keeper_t kp_d, kp_q;

    logic         drive_ab;
    logic         drive_ba;
    logic         loop_mode;
    logic         loop_idle;
    logic [W-1:0] loop_word;
    logic [W-1:0] reg_a;
    logic [W-1:0] reg_b;
    logic [W-1:0] a_level;

    assign drive_ab  = en_ab;
    assign drive_ba  = ~en_ba_n;
    assign loop_mode = drive_ab & drive_ba & ~src_ab & ~src_ba;
    assign loop_idle = loop_mode & ~a_ext & ~b_ext;

    always_comb begin
        if (a_ext) begin
            loop_word = a_in;
        end else if (b_ext) begin
            loop_word = b_in;
        end else begin
            loop_word = kp_q.keep;
        end
    end

    bxr_store #(.W(W)) store_a_i (
        .clk_i (st_clk_ab),
        .rst_i (st_rst_ab),
        .d_i   (a_in),
        .q_o   (reg_a)
    );

    bxr_store #(.W(W)) store_b_i (
        .clk_i (st_clk_ba),
        .rst_i (st_rst_ba),
        .d_i   (b_in),
        .q_o   (reg_b)
    );

    bxr_path_mux #(.W(W)) mux_ab_i (
        .en_i       (drive_ab),
        .sel_i      (src_ab),
        .loop_i     (loop_mode),
        .live_i     (a_in),
        .stored_i   (reg_a),
        .loop_val_i (loop_word),
        .out_o      (b_out),
        .oe_o       (b_oe)
    );

    bxr_path_mux #(.W(W)) mux_ba_i (
        .en_i       (drive_ba),
        .sel_i      (src_ba),
        .loop_i     (loop_mode),
        .live_i     (b_in),
        .stored_i   (reg_b),
        .loop_val_i (loop_word),
        .out_o      (a_out),
        .oe_o       (a_oe)
    );

    assign a_level = a_oe ? a_out : a_in;

    always_comb begin
        kp_d = kp_q;
        if (rst) begin
            kp_d.keep = '0;
        end else begin
            kp_d.keep = a_level;
        end
    end

    always_ff @(posedge clk) begin
        kp_q <= kp_d;
    end

    AST_OE_POLARITY: assert property (@(posedge clk) disable iff (rst)
        (b_oe == en_ab) && (a_oe == ~en_ba_n));                  // R2

    AST_OFF_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!en_ab |-> (b_out == '0)) and (en_ba_n |-> (a_out == '0))); // R3

    AST_LOOP_MATCH: assert property (@(posedge clk) disable iff (rst)
        loop_mode |-> (a_out == b_out));                         // R8

    AST_LOOP_KEEP: assert property (@(posedge clk) disable iff (rst)
        loop_idle |=> (!loop_idle || $stable(a_out)));           // R9

    AST_NO_GLITCH: assert property (@(posedge clk) disable iff (rst)
        (en_ab && !loop_mode && (reg_a == a_in)) |-> (b_out == a_in)); // R11

endmodule

// File: rtl/bidir_reg_xcvr.sv
module bidir_reg_xcvr #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LANES-1:0]        st_clk_ab,
    input  logic [LANES-1:0]        st_rst_ab,
    input  logic [LANES-1:0]        st_clk_ba,
    input  logic [LANES-1:0]        st_rst_ba,
    input  logic [LANES-1:0]        en_ab,
    input  logic [LANES-1:0]        en_ba_n,
    input  logic [LANES-1:0]        src_ab,
    input  logic [LANES-1:0]        src_ba,
    input  logic [LANES*LANE_W-1:0] a_in,
    input  logic [LANES-1:0]        a_ext,
    output logic [LANES*LANE_W-1:0] a_out,
    output logic [LANES-1:0]        a_oe,
    input  logic [LANES*LANE_W-1:0] b_in,
    input  logic [LANES-1:0]        b_ext,
    output logic [LANES*LANE_W-1:0] b_out,
    output logic [LANES-1:0]        b_oe
);

    localparam int BUS_W = LANES * LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LO = g * LANE_W;

        bxr_lane #(.W(LANE_W)) lane_i (
            .clk       (clk),
            .rst       (rst),
            .st_clk_ab (st_clk_ab[g]),
            .st_rst_ab (st_rst_ab[g]),
            .st_clk_ba (st_clk_ba[g]),
            .st_rst_ba (st_rst_ba[g]),
            .en_ab     (en_ab[g]),
            .en_ba_n   (en_ba_n[g]),
            .src_ab    (src_ab[g]),
            .src_ba    (src_ba[g]),
            .a_in      (a_in[LO +: LANE_W]),
            .a_ext     (a_ext[g]),
            .a_out     (a_out[LO +: LANE_W]),
            .a_oe      (a_oe[g]),
            .b_in      (b_in[LO +: LANE_W]),
            .b_ext     (b_ext[g]),
            .b_out     (b_out[LO +: LANE_W]),
            .b_oe      (b_oe[g])
        );
    end

    AST_BUS_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $countones(b_oe & ~en_ab) == 0);                         // R10

    if (BUS_W < 1) begin : g_bad_width
        initial $error("bidir_reg_xcvr: empty bus");
    end

endmodule

// File: tb/bidir_reg_xcvr_tb_top.sv
module bidir_reg_xcvr_tb_top;

    localparam int L  = 2;
    localparam int W  = 8;
    localparam int BW = L * W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [L-1:0]  st_clk_ab = '0, st_rst_ab = '1;
    logic [L-1:0]  st_clk_ba = '0, st_rst_ba = '1;
    logic [L-1:0]  en_ab = '0, en_ba_n = '1, src_ab = '0, src_ba = '0;
    logic [BW-1:0] a_in = '0, b_in = '0;
    logic [L-1:0]  a_ext = '0, b_ext = '0;
    logic [BW-1:0] a_out, b_out;
    logic [L-1:0]  a_oe, b_oe;

    int n_checks = 0;
    int n_errors = 0;

    logic [W-1:0] m_ra   [L];
    logic [W-1:0] m_rb   [L];
    logic [W-1:0] m_hold [L];
    logic [W-1:0] m_next [L];

    always #4 clk = ~clk;

    bidir_reg_xcvr #(.LANES(L), .LANE_W(W)) dut_i (
        .clk(clk), .rst(rst),
        .st_clk_ab(st_clk_ab), .st_rst_ab(st_rst_ab),
        .st_clk_ba(st_clk_ba), .st_rst_ba(st_rst_ba),
        .en_ab(en_ab), .en_ba_n(en_ba_n), .src_ab(src_ab), .src_ba(src_ba),
        .a_in(a_in), .a_ext(a_ext), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_ext(b_ext), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic check(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] path_word(input logic en, input logic sel, input logic loop,
                                                input logic [W-1:0] live, input logic [W-1:0] stored,
                                                input logic [W-1:0] keep);
        if (!en)       return '0;
        else if (loop) return keep;
        else if (sel)  return stored;
        else           return live;
    endfunction

    // Compare every lane with the model; compute the keeper's next value.
    task automatic check_all();
        for (int l = 0; l < L; l++) begin
            logic         eab, eba, lp;
            logic [W-1:0] ai, bi, lw, eb, ea;
            string        tb_, ta_;
            eab = en_ab[l];
            eba = ~en_ba_n[l];
            lp  = eab & eba & ~src_ab[l] & ~src_ba[l];
            ai  = a_in[l*W +: W];
            bi  = b_in[l*W +: W];
            lw  = a_ext[l] ? ai : (b_ext[l] ? bi : m_hold[l]);
            eb  = path_word(eab, src_ab[l], lp, ai, m_ra[l], lw);
            ea  = path_word(eba, src_ba[l], lp, bi, m_rb[l], lw);
            tb_ = !eab ? "R3" : (lp ? "R8" : (src_ab[l] ? "R5" : "R4"));
            ta_ = !eba ? "R3" : (lp ? "R8" : (src_ba[l] ? "R5" : "R4"));
            check(tb_, BW'(b_out[l*W +: W]), BW'(eb));
            check(ta_, BW'(a_out[l*W +: W]), BW'(ea));
            check("R2", BW'(b_oe[l]), BW'(eab));
            check("R2", BW'(a_oe[l]), BW'(eba));
            m_next[l] = eba ? ea : ai;
        end
    endtask

    // Called one time unit after a core rising edge with inputs already set.
    task automatic step(input logic [L-1:0] pab, input logic [L-1:0] pba);
        #1;
        st_clk_ab = pab;
        st_clk_ba = pba;
        for (int l = 0; l < L; l++) begin
            if (pab[l]) m_ra[l] = st_rst_ab[l] ? '0 : a_in[l*W +: W];
            if (pba[l]) m_rb[l] = st_rst_ba[l] ? '0 : b_in[l*W +: W];
        end
        #1;
        st_clk_ab = '0;
        st_clk_ba = '0;
        #1;
        check_all();
        @(posedge clk);
        for (int l = 0; l < L; l++) m_hold[l] = rst ? '0 : m_next[l];
        #1;
    endtask

    initial begin
        #(8 * 150000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [BW-1:0] saved;
        void'($urandom(32'd7351));
        for (int l = 0; l < L; l++) begin
            m_ra[l] = '0; m_rb[l] = '0; m_hold[l] = '0; m_next[l] = '0;
        end
        // Reset: pulse storage clocks with resets held.
        #1;
        st_clk_ab = '1; st_clk_ba = '1;
        #1;
        st_clk_ab = '0; st_clk_ba = '0;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        st_rst_ab = '0;
        st_rst_ba = '0;

        // R1: stored path after reset drives zero
        en_ab = '1; en_ba_n = '0; src_ab = '1; src_ba = '1;
        a_in = 16'hA5A5; b_in = 16'h5A5A;
        step('0, '0);
        check("R1", b_out, '0);
        check("R1", a_out, '0);

        // R6: capture while disabled and live-selected
        en_ab = '0; en_ba_n = '1; src_ab = '0; src_ba = '0;
        a_in = 16'hC35A; b_in = 16'h1E96;
        step('1, '1);
        en_ab = '1; en_ba_n = '0; src_ab = '1; src_ba = '1;
        a_in = 16'h0000; b_in = 16'hFFFF;
        step('0, '0);
        check("R6", b_out, 16'hC35A);
        check("R6", a_out, 16'h1E96);

        // R7: select and enable churn with no storage edges
        for (int k = 0; k < 6; k++) begin
            en_ab = L'($urandom); en_ba_n = L'($urandom);
            src_ab = L'($urandom); src_ba = L'($urandom);
            a_in = BW'($urandom); b_in = BW'($urandom);
            step('0, '0);
        end
        en_ab = '1; en_ba_n = '0; src_ab = '1; src_ba = '1;
        a_ext = '0; b_ext = '0;
        step('0, '0);
        check("R7", b_out, 16'hC35A);
        check("R7", a_out, 16'h1E96);

        // R10: capture only in lane 0, lane 1 unchanged
        a_in = 16'h7711;
        step(2'b01, '0);
        check("R10", b_out, 16'hC311);

        // R1: storage reset of lane 1 A-side register only
        st_rst_ab = 2'b10;
        step(2'b10, '0);
        st_rst_ab = '0;
        step('0, '0);
        check("R1", b_out, 16'h0011);

        // R11: equal stored and live words, select toggles
        a_in = 16'h0011;
        saved = b_out;
        src_ab = '0;
        #1;
        check("R11", b_out, saved);
        src_ab = '1;
        #1;
        check("R11", b_out, saved);
        step('0, '0);

        // R9 and R8: keeper entry with no outside driver
        en_ab = '0; en_ba_n = '1; a_in = 16'h3C3C;
        step('0, '0);
        en_ab = '1; en_ba_n = '0; src_ab = '0; src_ba = '0;
        a_ext = '0; b_ext = '0; a_in = 16'h9999; b_in = 16'h6666;
        step('0, '0);
        check("R9", a_out, 16'h3C3C);
        check("R9", b_out, 16'h3C3C);
        b_ext = '1; b_in = 16'h7777;
        step('0, '0);
        check("R8", a_out, 16'h7777);
        b_ext = '0; b_in = 16'h0102;
        step('0, '0);
        check("R8", a_out, 16'h7777);
        a_ext = 2'b01; a_in = 16'h4455;
        step('0, '0);
        check("R8", b_out, 16'h7755);
        a_ext = '0;

        // Random mix, biased toward loop mode
        for (int k = 0; k < 600; k++) begin
            en_ab = L'($urandom); en_ba_n = L'($urandom);
            src_ab = L'($urandom); src_ba = L'($urandom);
            if (($urandom % 3) == 0) begin
                en_ab = '1; en_ba_n = '0;
                src_ab = src_ab & L'($urandom);
                src_ba = src_ba & L'($urandom);
                src_ab = '0; src_ba = (($urandom % 2) == 0) ? '0 : src_ba;
            end
            a_ext = L'($urandom) & L'($urandom);
            b_ext = L'($urandom) & L'($urandom);
            a_in = BW'($urandom); b_in = BW'($urandom);
            step(L'($urandom), L'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule